// File: doc/BRIEF.md
# Pending-Destination Issue Scoreboard

This block sits at the issue stage of an in-order pipeline whose execution units take different numbers of cycles, such as integer ALUs beside multi-cycle floating-point adders, multipliers and dividers. It records every destination register that belongs to an issued instruction whose result has not yet been written back. The integer file and the floating-point file each have their own set of entries. Because instructions that move data between the two files read one file and write the other, each operand carries its own file-select bit and is checked against the entries of that file.

Each cycle the decoder presents up to two source operands and one destination, each with an enable, a file select and a register number, plus the latency of the unit the instruction goes to. The block raises `stall` if a source names a pending register (read-after-write) or if the destination is already pending (write-after-write). Write-after-read needs no check, because operands are read at issue. An accepted instruction reserves its destination. A timed entry frees itself after the given number of cycles. An entry reserved with latency zero waits for an explicit writeback notification, which suits units whose latency varies.

Top module: `dest_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, and after any later reset, no register is pending, so no instruction stalls.
- R2: With `iss_valid` high, `stall` is high in the same cycle if an enabled source names a pending register of its selected file (`*_fp`=0 integer, 1 floating-point). With `iss_valid` low, `stall` is low.
- R3: The two files are independent. A pending integer register N does not block a read or write of floating-point register N, and the reverse also holds.
- R4: With `iss_valid` high, `stall` is high if the enabled destination is already pending in its file.
- R5: An accepted instruction with `rd_lat` = L (1..31) leaves its destination pending for exactly the L cycles after the issue edge. From the next cycle on, the destination is free.
- R6: A destination accepted with `rd_lat` = 0 stays pending until a `wb_valid` notification names it. The notified register already counts as free in the cycle of the notification, and a notification leaves every other register unchanged.
- R7: Integer register 0 is never pending. Reads and writes of it never cause a stall.
- R8: A stalled instruction reserves nothing.
- R9: If a register is cleared by a notification and newly reserved in the same cycle, it ends up pending, because the reservation takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| rs1_en | input | 1 | First source is used |
| rs1_fp | input | 1 | First source file: 0 integer, 1 floating-point |
| rs1_idx | input | 5 | First source register number |
| rs2_en | input | 1 | Second source is used |
| rs2_fp | input | 1 | Second source file |
| rs2_idx | input | 5 | Second source register number |
| rd_en | input | 1 | Instruction writes a destination |
| rd_fp | input | 1 | Destination file |
| rd_idx | input | 5 | Destination register number |
| rd_lat | input | 5 | Cycles until forwardable; 0 = wait for notification |
| wb_valid | input | 1 | Writeback notification |
| wb_fp | input | 1 | File of the notified register |
| wb_idx | input | 5 | Notified register number |
| stall | output | 1 | Hold the presented instruction |

## Verification
The bench builds the block with its default parameters: 32 registers per file and a 5-bit latency field. These values bring the shortest timed latency (1), a 3-cycle latency and the untimed latency-zero mode within reach. They also make it possible to place the same register number in both files, so a cross-file mistake shows up as a wrong stall. The stimulus covers integer register 0 and a writeback and a reservation that land on one register in the same cycle.

// File: rtl/sb_pkg.sv
// Package: shared encodings for the pending-destination scoreboard.
// Assumes the file select is a single bit; the flat entry index is {file, reg}.
package sb_pkg;
    typedef enum logic {
        RF_INT = 1'b0,
        RF_FP  = 1'b1
    } rf_sel_e;
endpackage

// File: rtl/sb_slot.sv
// Module: sb_slot
// One scoreboard entry: a pending flag and a countdown of the cycles left.
// Assumes: reserve and wb_clr arrive already decoded for this entry. A
// reservation with lat==0 waits for wb_clr. A reservation beats a clear.
module sb_slot #(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reserve,
    input  logic [LAT_W-1:0] lat,
    input  logic             wb_clr,
    output logic             pend
);
    logic [LAT_W-1:0] cnt;

    // Purpose: reserve, clear, or count down toward the forwardable cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (reserve) begin
            pend <= 1'b1;
            cnt  <= lat;
        end else if (wb_clr) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (pend && cnt != '0) begin
            if (cnt == LAT_W'(1)) begin
                pend <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt - LAT_W'(1);
            end
        end
    end

    AST_RESERVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        reserve |=> pend); // R9
    AST_TIMED_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cnt == LAT_W'(1) && !reserve) |=> !pend); // R5
    AST_TIMED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cnt > LAT_W'(1) && !reserve && !wb_clr) |=> (pend && cnt == $past(cnt) - LAT_W'(1))); // R5
    AST_UNTIMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cnt == '0 && !reserve && !wb_clr) |=> pend); // R6
    AST_NOTIFY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_clr && !reserve) |=> !pend); // R6
endmodule

// File: rtl/sb_hazard.sv
// Module: sb_hazard
// Looks up the pending flags of up to two sources and one destination.
// Assumes: the pending vector is indexed {file, reg} and that a register
// being notified this cycle has already been masked out by the caller.
module sb_hazard #(
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS),
    localparam int TOTAL = 2 * NREGS
) (
    input  logic [TOTAL-1:0] free_mask_pend,
    input  logic             iss_valid,
    input  logic             a_en,
    input  logic             a_fp,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             b_en,
    input  logic             b_fp,
    input  logic [IDX_W-1:0] b_idx,
    input  logic             d_en,
    input  logic             d_fp,
    input  logic [IDX_W-1:0] d_idx,
    output logic             raw_hit,
    output logic             waw_hit,
    output logic             stall
);
    logic a_pend, b_pend, d_pend;

    // Purpose: pick the flag of each operand from its own file.
    always_comb begin
        a_pend = free_mask_pend[{a_fp, a_idx}];
        b_pend = free_mask_pend[{b_fp, b_idx}];
        d_pend = free_mask_pend[{d_fp, d_idx}];
    end

    // Purpose: combine the read and write conflicts into one stall request.
    always_comb begin
        raw_hit = (a_en && a_pend) || (b_en && b_pend);
        waw_hit = d_en && d_pend;
        stall   = iss_valid && (raw_hit || waw_hit);
    end
endmodule

// File: rtl/dest_scoreboard.sv
// Module: dest_scoreboard (top)
// Issue-stage scoreboard for the integer and floating-point files. Holds one
// sb_slot per register (integer register 0 is tied off), masks out a
// register named by this cycle's writeback notification, and raises stall
// on read-after-write or write-after-write conflicts.
// Assumes: in-order issue. Operands are read at issue, so write-after-read
// cannot occur.
module dest_scoreboard #(
    parameter int NREGS = 32,
    parameter int LAT_W = 5,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic             rs1_en,
    input  logic             rs1_fp,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic             rs2_en,
    input  logic             rs2_fp,
    input  logic [IDX_W-1:0] rs2_idx,
    input  logic             rd_en,
    input  logic             rd_fp,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [LAT_W-1:0] rd_lat,
    input  logic             wb_valid,
    input  logic             wb_fp,
    input  logic [IDX_W-1:0] wb_idx,
    output logic             stall
);
    import sb_pkg::*;

    localparam int TOTAL = 2 * NREGS;
    localparam int FLAT_W = IDX_W + 1;

    logic [TOTAL-1:0] pend_vec;
    logic [TOTAL-1:0] wb_hot;
    logic [TOTAL-1:0] rsv_hot;
    logic [TOTAL-1:0] eff_pend;
    logic             raw_hit, waw_hit;
    logic             accept;

    // Purpose: one-hot decode of the writeback notification.
    always_comb begin
        wb_hot = '0;
        if (wb_valid) wb_hot[{wb_fp, wb_idx}] = 1'b1;
    end

    // Purpose: a notified register counts as free in this cycle's checks.
    always_comb eff_pend = pend_vec & ~wb_hot;

    sb_hazard #(.NREGS(NREGS)) u_hazard (
        .free_mask_pend (eff_pend),
        .iss_valid      (iss_valid),
        .a_en           (rs1_en),
        .a_fp           (rs1_fp),
        .a_idx          (rs1_idx),
        .b_en           (rs2_en),
        .b_fp           (rs2_fp),
        .b_idx          (rs2_idx),
        .d_en           (rd_en),
        .d_fp           (rd_fp),
        .d_idx          (rd_idx),
        .raw_hit        (raw_hit),
        .waw_hit        (waw_hit),
        .stall          (stall)
    );

    // Purpose: an instruction that issues reserves its destination.
    always_comb begin
        accept  = iss_valid && !stall;
        rsv_hot = '0;
        if (accept && rd_en) rsv_hot[{rd_fp, rd_idx}] = 1'b1;
    end

    // Purpose: one entry per register; integer register 0 has none.
    for (genvar g = 0; g < TOTAL; g++) begin : g_slot
        if (g == int'({RF_INT, {IDX_W{1'b0}}})) begin : g_zero
            assign pend_vec[g] = 1'b0;
        end else begin : g_live
            sb_slot #(.LAT_W(LAT_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .reserve (rsv_hot[g]),
                .lat     (rd_lat),
                .wb_clr  (wb_hot[g]),
                .pend    (pend_vec[g])
            );
        end
    end

    AST_INT0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vec[0]); // R7
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !stall); // R2
    AST_ISSUED_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rs1_en) |-> !eff_pend[FLAT_W'({rs1_fp, rs1_idx})]); // R2
    AST_ISSUED_DST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rd_en) |-> !eff_pend[FLAT_W'({rd_fp, rd_idx})]); // R4
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !wb_valid && rd_en && !pend_vec[{rd_fp, rd_idx}] && rd_lat == '0)
        |=> !pend_vec[$past({rd_fp, rd_idx})]); // R8
endmodule

// File: tb/tb_dest_scoreboard.sv
module tb_dest_scoreboard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic       rs1_en = 1'b0, rs1_fp = 1'b0; logic [4:0] rs1_idx = '0;
    logic       rs2_en = 1'b0, rs2_fp = 1'b0; logic [4:0] rs2_idx = '0;
    logic       rd_en = 1'b0, rd_fp = 1'b0;   logic [4:0] rd_idx = '0;
    logic [4:0] rd_lat = '0;
    logic       wb_valid = 1'b0, wb_fp = 1'b0; logic [4:0] wb_idx = '0;
    logic       stall;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dest_scoreboard dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .rs1_en(rs1_en), .rs1_fp(rs1_fp), .rs1_idx(rs1_idx),
        .rs2_en(rs2_en), .rs2_fp(rs2_fp), .rs2_idx(rs2_idx),
        .rd_en(rd_en), .rd_fp(rd_fp), .rd_idx(rd_idx), .rd_lat(rd_lat),
        .wb_valid(wb_valid), .wb_fp(wb_fp), .wb_idx(wb_idx), .stall(stall)
    );

    // operand fields are {enable, file, register}
    typedef struct packed {
        logic       v;
        logic [6:0] a;
        logic [6:0] b;
        logic [6:0] d;
        logic [4:0] lat;
        logic [6:0] w;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam logic [6:0] NO = 7'h00;
    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b1, NO, NO, {2'b11, 5'd3}, 5'd3, NO, 1'b0, 4'd4},          // R4 write fp3, L=3
        '{1'b1, {2'b11, 5'd3}, NO, NO, 5'd0, NO, 1'b1, 4'd2},          // R2 read fp3
        '{1'b1, {2'b10, 5'd3}, NO, NO, 5'd0, NO, 1'b0, 4'd3},          // R3 int3 independent
        '{1'b1, NO, NO, {2'b11, 5'd3}, 5'd2, NO, 1'b1, 4'd4},          // R4 WAW fp3
        '{1'b1, NO, {2'b11, 5'd3}, NO, 5'd0, NO, 1'b0, 4'd5},          // R5 fp3 free after 3
        '{1'b1, NO, NO, {2'b10, 5'd5}, 5'd0, NO, 1'b0, 4'd6},          // R6 untimed int5
        '{1'b0, NO, {2'b10, 5'd5}, NO, 5'd0, NO, 1'b0, 4'd2},          // R2 idle no stall
        '{1'b1, NO, {2'b10, 5'd5}, NO, 5'd0, NO, 1'b1, 4'd6},          // R6 still pending
        '{1'b1, {2'b11, 5'd5}, NO, NO, 5'd0, NO, 1'b0, 4'd3},          // R3 fp5 free
        '{1'b1, NO, NO, {2'b10, 5'd5}, 5'd0, {2'b10, 5'd5}, 1'b0, 4'd9}, // R9 clear+reserve
        '{1'b1, {2'b10, 5'd5}, NO, NO, 5'd0, NO, 1'b1, 4'd9},          // R9 reservation kept
        '{1'b1, {2'b10, 5'd0}, NO, {2'b10, 5'd0}, 5'd4, NO, 1'b0, 4'd7}, // R7 write int0
        '{1'b1, {2'b10, 5'd0}, NO, NO, 5'd0, NO, 1'b0, 4'd7},          // R7 read int0
        '{1'b1, {2'b10, 5'd5}, NO, {2'b11, 5'd7}, 5'd1, NO, 1'b1, 4'd8}, // R8 stalled write fp7
        '{1'b1, {2'b11, 5'd7}, NO, NO, 5'd0, NO, 1'b0, 4'd8},          // R8 fp7 not reserved
        '{1'b0, NO, NO, NO, 5'd0, {2'b10, 5'd5}, 1'b0, 4'd6},          // R6 notify int5
        '{1'b1, {2'b10, 5'd5}, NO, NO, 5'd0, NO, 1'b0, 4'd6},          // R6 int5 free
        '{1'b1, NO, NO, {2'b11, 5'd9}, 5'd1, NO, 1'b0, 4'd5},          // R5 write fp9 L=1
        '{1'b1, NO, {2'b11, 5'd9}, NO, 5'd0, NO, 1'b1, 4'd5},          // R5 one cycle pending
        '{1'b1, NO, {2'b11, 5'd9}, NO, 5'd0, NO, 1'b0, 4'd5}           // R5 fp9 free
    };

    task automatic apply(input vec_t t);
        iss_valid = t.v;
        {rs1_en, rs1_fp, rs1_idx} = t.a;
        {rs2_en, rs2_fp, rs2_idx} = t.b;
        {rd_en, rd_fp, rd_idx} = t.d;
        rd_lat = t.lat;
        {wb_valid, wb_fp, wb_idx} = t.w;
    endtask

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (stall !== exp) begin
            n_bad++;
            $display("FAIL %s: stall=%b expected %b", req, stall, exp);
        end
    endtask

    // one cycle: drive after the falling edge, sample before the rising edge
    task automatic step(input vec_t t, input logic exp, input string req);
        @(negedge clk);
        apply(t);
        #2 check(exp, req);
    endtask

    task automatic go_idle();
        @(negedge clk);
        apply('0);
    endtask

    initial begin
        #150000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: run hung, stall=%b expected completion", stall);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state: every register of both files is free
        for (int f = 0; f < 2; f++) begin
            for (int r = 0; r < 32; r++) begin
                step('{1'b1, {1'b1, f[0], r[4:0]}, NO, NO, 5'd0, NO, 1'b0, 4'd1}, 1'b0, "R1");
            end
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(TBL[i], TBL[i].exp, $sformatf("R%0d", TBL[i].req));
        end

        // R3/R4 cross-file writes and R6 notification of another file
        step('{1'b1, NO, NO, {2'b10, 5'd6}, 5'd0, NO, 1'b0, 4'd4}, 1'b0, "R4");
        step('{1'b1, NO, NO, {2'b11, 5'd6}, 5'd0, NO, 1'b0, 4'd3}, 1'b0, "R3");
        step('{1'b1, NO, NO, {2'b10, 5'd6}, 5'd2, NO, 1'b0, 4'd4}, 1'b1, "R4");
        step('{1'b0, NO, NO, NO, 5'd0, {2'b11, 5'd6}, 1'b0, 4'd6}, 1'b0, "R6");
        step('{1'b1, {2'b10, 5'd6}, NO, NO, 5'd0, NO, 1'b0, 4'd6}, 1'b1, "R6");
        // R6 notified register is free in the notification cycle
        step('{1'b1, {2'b10, 5'd6}, NO, NO, 5'd0, {2'b10, 5'd6}, 1'b0, 4'd6}, 1'b0, "R6");
        step('{1'b1, NO, {2'b10, 5'd6}, NO, 5'd0, NO, 1'b0, 4'd6}, 1'b0, "R6");

        // R1 a later reset drops untimed reservations
        step('{1'b1, NO, NO, {2'b11, 5'd2}, 5'd0, NO, 1'b0, 4'd1}, 1'b0, "R1");
        step('{1'b1, {2'b11, 5'd2}, NO, NO, 5'd0, NO, 1'b1, 4'd1}, 1'b1, "R1");
        go_idle();
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        step('{1'b1, {2'b11, 5'd2}, NO, NO, 5'd0, NO, 1'b0, 4'd1}, 1'b0, "R1");

        go_idle();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule